// File: doc/BRIEF.md
# Flash Command and Address Cycle Generator

This block sits between a flash controller's request logic and the low-level pin sequencer of a raw NAND-style flash device. It takes one high-level request and expands it into the ordered series of command bytes, address bytes and data-transfer requests the device expects. The request carries an operation code, a column and a page number, and each of the two address fields has its own valid flag. Every item leaves on a valid/ready stream, tagged with its kind. Pin timing is handled downstream.

Sub-page reads are emulated with full-page reads. Every read sends column 0 to the device, and the requested column is kept in a register so a later buffer-read stage knows where to start. A read of the upper half-page adds 256 to that stored column. A spare-only read raises a flag. A program setup first re-reads the same page, then issues the setup command. The device geometry comes from configuration inputs: a large-page flag (page bigger than 512 bytes), the number of page-address bytes, and the bus width.

The state machine has eight states:
- `S_IDLE` waits for a request.
- `S_PRE` emits a data-input request.
- `S_CMD` emits the command byte.
- `S_COL_LO` and `S_COL_HI` emit the column bytes.
- `S_ROW` emits the page bytes.
- `S_CONF` emits the read-confirm command.
- `S_XFER` emits the trailing transfer request.

Transitions:
- `S_IDLE` goes to `S_PRE` on a commit request, and to `S_CMD` on any other supported request.
- `S_PRE` goes to `S_CMD`.
- `S_CMD` goes to the column states, to `S_ROW`, or straight to the address exit.
- `S_COL_LO` goes to `S_COL_HI` for large pages, otherwise on as `S_COL_HI` would.
- `S_COL_HI` goes to `S_ROW` or to the address exit.
- `S_ROW` repeats until the last page byte, then takes the address exit.
- The address exit goes to `S_CONF` for large-page reads, to `S_XFER` when a transfer request follows, otherwise to the finish.
- `S_CONF` goes to `S_XFER`.
- `S_XFER` goes to the finish.
- The finish returns to `S_IDLE`, or to `S_CMD` with the setup command loaded when a program setup is still pending.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is high only in `S_IDLE` and is high after reset. While `out_valid` is high and `out_ready` is low, `out_kind` and `out_byte` hold their values. The item kinds are: 0 command, 1 address, 2 data-output request, 3 data-input request, 4 ID-read request, 5 status-read request. Transfer requests carry byte 0x00.
- R2: When column bytes are sent, the low byte of the column goes first. When `cfg_large_page` is 1, a second byte holding column bits 15:8 follows.
- R3: The page address goes out least-significant byte first. The number of page bytes is `cfg_row_bytes`, where 0 counts as 1 and values above ROW_MAX are clipped to ROW_MAX. No page bytes are sent when `req_page_vld` is 0 or the operation takes no address.
- R4: The read operations (op 0 page read, op 1 upper half read, op 2 spare-only read) all emit the same sequence. It is command 0x00, then column bytes of value 0 sent even when `req_col_vld` is 0, then the page bytes. Next comes command 0x30 only if `cfg_large_page` is 1, and last a data-output request.
- R5: Op 1 stores as its column the requested column (0 if absent) plus 256, wrapping at COL_W bits.
- R6: Op 2 sets `spare_out` to 1. Every other supported operation clears it.
- R7: Op 3 (program setup) emits the full op 0 sequence for the same page. It then emits command 0x80, column bytes of value 0, and the page bytes, with no transfer request.
- R8: Op 4 (program commit) emits a data-input request, then command 0x10. It sends no address bytes, whatever the valid flags say.
- R9: The following commands send column bytes only when `req_col_vld` is 1 and page bytes only when `req_page_vld` is 1:
  - op 5 (erase start) sends 0x60;
  - op 6 (erase confirm) sends 0xD0;
  - op 7 (ID read) sends 0x90, followed by an ID-read request;
  - op 8 (status read) sends 0x70, followed by a status-read request.
- R10: After op 8 is accepted, `col_out` is 1 if `cfg_bus16` is 1 and 0 otherwise.
- R11: Op codes 9 to 15 are accepted and dropped. They produce no stream item and leave `col_out` and `spare_out` unchanged.
- R12: For ops 0, 2, 3, 4, 5, 6 and 7, `col_out` takes the requested column, or 0 when `req_col_vld` is 0. It updates on the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_large_page | input | 1 | Page size above 512 bytes |
| cfg_row_bytes | input | ROWC_W | Number of page-address bytes |
| cfg_bus16 | input | 1 | Device has a 16-bit data bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_op | input | 4 | Operation code |
| req_col | input | COL_W | Column |
| req_col_vld | input | 1 | Column present |
| req_page | input | PAGE_W | Page number |
| req_page_vld | input | 1 | Page present |
| out_valid | output | 1 | Stream item valid |
| out_ready | input | 1 | Stream sink ready |
| out_kind | output | 3 | Item kind |
| out_byte | output | 8 | Command or address byte |
| col_out | output | COL_W | Stored start column |
| spare_out | output | 1 | Stored spare-only flag |

## Verification
The bench sweeps every operation code against both address-valid flags, both page sizes and every page-byte count from 0 to ROW_MAX. The sink stalls on a fixed pattern while this runs.

The riskiest corners, and how a faulty design would show up:
- Program setup must chain a read before the setup command. A design that forgot to reload the page after the pre-read would send the page bytes shifted to zero.
- Column bytes must be suppressed on reads. A design that forwarded the requested column would leak non-zero address bytes.
- Status reads overwrite the stored column with the bus-width flag, and the upper half read wraps the stored column at 16 bits. A wrong adder width or a missed override shows up directly on `col_out`.
- Unsupported codes must leave the stored state alone. A design that cleared the spare flag on them would fail right after a spare-only read.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [3:0] OP_READ      = 4'd0;
    localparam logic [3:0] OP_READ_HI   = 4'd1;
    localparam logic [3:0] OP_READ_SPR  = 4'd2;
    localparam logic [3:0] OP_PRG_SETUP = 4'd3;
    localparam logic [3:0] OP_PRG_GO    = 4'd4;
    localparam logic [3:0] OP_ERS_START = 4'd5;
    localparam logic [3:0] OP_ERS_GO    = 4'd6;
    localparam logic [3:0] OP_ID        = 4'd7;
    localparam logic [3:0] OP_STAT      = 4'd8;

    localparam logic [7:0] CB_READ    = 8'h00;
    localparam logic [7:0] CB_CONFIRM = 8'h30;
    localparam logic [7:0] CB_SETUP   = 8'h80;
    localparam logic [7:0] CB_COMMIT  = 8'h10;
    localparam logic [7:0] CB_ERS1    = 8'h60;
    localparam logic [7:0] CB_ERS2    = 8'hD0;
    localparam logic [7:0] CB_ID      = 8'h90;
    localparam logic [7:0] CB_STAT    = 8'h70;

    typedef enum logic [2:0] {
        K_CMD   = 3'd0,
        K_ADDR  = 3'd1,
        K_XOUT  = 3'd2,
        K_XIN   = 3'd3,
        K_XID   = 3'd4,
        K_XSTAT = 3'd5
    } item_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_CMD, S_COL_LO, S_COL_HI, S_ROW, S_CONF, S_XFER
    } seq_state_t;

    typedef struct packed {
        logic       ok;
        logic       pre_in;
        logic [7:0] cmd;
        logic       col_force;
        logic       col_opt;
        logic       page_ok;
        logic       read_like;
        logic       post_en;
        item_kind_t post_kind;
        logic       setup;
    } op_dec_t;

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
    import flash_seq_pkg::*;
(
    input  logic [3:0] op,
    output op_dec_t    dec
);
    always_comb begin
        dec = '0;
        dec.post_kind = K_XOUT;
        unique case (op)
            OP_READ, OP_READ_HI, OP_READ_SPR, OP_PRG_SETUP: begin
                dec.ok        = 1'b1;
                dec.cmd       = CB_READ;
                dec.col_force = 1'b1;
                dec.page_ok   = 1'b1;
                dec.read_like = 1'b1;
                dec.post_en   = 1'b1;
                dec.setup     = (op == OP_PRG_SETUP);
            end
            OP_PRG_GO: begin
                dec.ok     = 1'b1;
                dec.pre_in = 1'b1;
                dec.cmd    = CB_COMMIT;
            end
            OP_ERS_START, OP_ERS_GO: begin
                dec.ok      = 1'b1;
                dec.cmd     = (op == OP_ERS_START) ? CB_ERS1 : CB_ERS2;
                dec.col_opt = 1'b1;
                dec.page_ok = 1'b1;
            end
            OP_ID, OP_STAT: begin
                dec.ok        = 1'b1;
                dec.cmd       = (op == OP_ID) ? CB_ID : CB_STAT;
                dec.col_opt   = 1'b1;
                dec.page_ok   = 1'b1;
                dec.post_en   = 1'b1;
                dec.post_kind = (op == OP_ID) ? K_XID : K_XSTAT;
            end
            default: dec.ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fseq_coltrack.sv
module fseq_coltrack
    import flash_seq_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [3:0]       op,
    input  logic [COL_W-1:0] col,
    input  logic             col_vld,
    input  logic             bus16,
    output logic [COL_W-1:0] col_q,
    output logic             spare_q
);
    localparam logic [COL_W-1:0] HALF_OFS = COL_W'(256);

    logic [COL_W-1:0] base;
    assign base = col_vld ? col : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q   <= '0;
            spare_q <= 1'b0;
        end else if (take) begin
            spare_q <= (op == OP_READ_SPR);
            if (op == OP_READ_HI)
                col_q <= base + HALF_OFS;
            else if (op == OP_STAT)
                col_q <= {{(COL_W-1){1'b0}}, bus16};
            else
                col_q <= base;
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int COL_W   = 16,
    parameter int PAGE_W  = 24,
    parameter int ROW_MAX = 3,
    localparam int ROWC_W = $clog2(ROW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_large_page,
    input  logic [ROWC_W-1:0] cfg_row_bytes,
    input  logic              cfg_bus16,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_col_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_page_vld,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_kind,
    output logic [7:0]        out_byte,
    output logic [COL_W-1:0]  col_out,
    output logic              spare_out
);
    seq_state_t        state, state_n;
    op_dec_t           dec;
    logic [7:0]        cmd_q;
    logic [COL_W-1:0]  cadr_q;
    logic              send_col_q, send_page_q, read_like_q, post_en_q, setup_q;
    item_kind_t        post_kind_q;
    logic [PAGE_W-1:0] page_sh, page_hold;
    logic [ROWC_W-1:0] row_idx, row_lim;
    logic              take, good_take, fire, row_last, addr_exit, fin_now, load_setup;
    seq_state_t        addr_next, fin_next;
    item_kind_t        kind_c;

    fseq_decode u_dec (.op(req_op), .dec(dec));

    assign take      = req_valid && req_ready;
    assign good_take = take && dec.ok;
    assign fire      = out_valid && out_ready;

    fseq_coltrack #(.COL_W(COL_W)) u_col (
        .clk(clk), .rst_n(rst_n), .take(good_take), .op(req_op),
        .col(req_col), .col_vld(req_col_vld), .bus16(cfg_bus16),
        .col_q(col_out), .spare_q(spare_out)
    );

    always_comb begin
        if (cfg_row_bytes == '0)
            row_lim = ROWC_W'(1);
        else if (cfg_row_bytes > ROWC_W'(ROW_MAX))
            row_lim = ROWC_W'(ROW_MAX);
        else
            row_lim = cfg_row_bytes;
    end
    assign row_last = (row_idx == row_lim - ROWC_W'(1));

    assign fin_next  = setup_q ? S_CMD : S_IDLE;
    assign addr_next = (read_like_q && cfg_large_page) ? S_CONF :
                       post_en_q ? S_XFER : fin_next;
    assign addr_exit = (state == S_CMD    && !send_col_q && !send_page_q) ||
                       (state == S_COL_LO && !cfg_large_page && !send_page_q) ||
                       (state == S_COL_HI && !send_page_q) ||
                       (state == S_ROW    && row_last);
    assign fin_now    = (state == S_XFER) ||
                        (addr_exit && !(read_like_q && cfg_large_page) && !post_en_q);
    assign load_setup = fire && fin_now && setup_q;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (good_take) state_n = dec.pre_in ? S_PRE : S_CMD;
            S_PRE:    if (fire) state_n = S_CMD;
            S_CMD:    if (fire) state_n = send_col_q ? S_COL_LO :
                                          send_page_q ? S_ROW : addr_next;
            S_COL_LO: if (fire) state_n = cfg_large_page ? S_COL_HI :
                                          send_page_q ? S_ROW : addr_next;
            S_COL_HI: if (fire) state_n = send_page_q ? S_ROW : addr_next;
            S_ROW:    if (fire && row_last) state_n = addr_next;
            S_CONF:   if (fire) state_n = S_XFER;
            S_XFER:   if (fire) state_n = fin_next;
            default:  state_n = S_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cmd_q       <= '0;
            cadr_q      <= '0;
            send_col_q  <= 1'b0;
            send_page_q <= 1'b0;
            read_like_q <= 1'b0;
            post_en_q   <= 1'b0;
            post_kind_q <= K_XOUT;
            setup_q     <= 1'b0;
            page_sh     <= '0;
            page_hold   <= '0;
            row_idx     <= '0;
        end else begin
            state <= state_n;
            if (good_take) begin
                cmd_q       <= dec.cmd;
                cadr_q      <= dec.col_force ? '0 : req_col;
                send_col_q  <= dec.col_force || (dec.col_opt && req_col_vld);
                send_page_q <= dec.page_ok && req_page_vld;
                read_like_q <= dec.read_like;
                post_en_q   <= dec.post_en;
                post_kind_q <= dec.post_kind;
                setup_q     <= dec.setup;
                page_sh     <= req_page;
                page_hold   <= req_page;
                row_idx     <= '0;
            end else if (load_setup) begin
                cmd_q       <= CB_SETUP;
                cadr_q      <= '0;
                send_col_q  <= 1'b1;
                read_like_q <= 1'b0;
                post_en_q   <= 1'b0;
                setup_q     <= 1'b0;
                page_sh     <= page_hold;
                row_idx     <= '0;
            end else if (fire && state == S_ROW) begin
                page_sh <= page_sh >> 8;
                row_idx <= row_idx + ROWC_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b1;
        kind_c    = K_CMD;
        out_byte  = 8'h00;
        unique case (state)
            S_IDLE:   out_valid = 1'b0;
            S_PRE:    kind_c = K_XIN;
            S_CMD:    out_byte = cmd_q;
            S_COL_LO: begin kind_c = K_ADDR; out_byte = cadr_q[7:0];  end
            S_COL_HI: begin kind_c = K_ADDR; out_byte = cadr_q[15:8]; end
            S_ROW:    begin kind_c = K_ADDR; out_byte = page_sh[7:0]; end
            S_CONF:   out_byte = CB_CONFIRM;
            S_XFER:   kind_c = post_kind_q;
            default:  out_valid = 1'b0;
        endcase
        out_kind  = kind_c;
        req_ready = (state == S_IDLE);
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int COL_W   = 16,
    parameter int PAGE_W  = 24,
    parameter int ROWC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_large_page,
    input logic [ROWC_W-1:0] cfg_row_bytes,
    input logic              cfg_bus16,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_op,
    input logic [COL_W-1:0]  req_col,
    input logic              req_col_vld,
    input logic [PAGE_W-1:0] req_page,
    input logic              req_page_vld,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_kind,
    input logic [7:0]        out_byte,
    input logic [COL_W-1:0]  col_out,
    input logic              spare_out
);
    logic take;
    assign take = req_valid && req_ready;

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready); // R1
    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_byte)); // R1
    AST_SPARE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_op == 4'd2 |=> spare_out); // R6
    AST_HALF_COL: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_op == 4'd1 && req_col_vld |=> col_out == $past(req_col) + COL_W'(256)); // R5
    AST_STAT_COL: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_op == 4'd8 |=> col_out == COL_W'($past(cfg_bus16))); // R10
    AST_DROP_UNSUP: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_op > 4'd8 |=> req_ready && !out_valid && $stable(col_out) && $stable(spare_out)); // R11
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.COL_W(COL_W), .PAGE_W(PAGE_W), .ROWC_W(ROWC_W)) u_chk (.*);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
    localparam int COL_W = 16, PAGE_W = 24, ROW_MAX = 3, ROWC_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_large_page = 0, cfg_bus16 = 0;
    logic [ROWC_W-1:0] cfg_row_bytes = '0;
    logic req_valid = 0, req_col_vld = 0, req_page_vld = 0, out_ready = 1;
    logic [3:0] req_op = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [PAGE_W-1:0] req_page = '0;
    logic req_ready, out_valid, spare_out;
    logic [2:0] out_kind;
    logic [7:0] out_byte;
    logic [COL_W-1:0] col_out;

    flash_cmd_seq #(.COL_W(COL_W), .PAGE_W(PAGE_W), .ROW_MAX(ROW_MAX)) uut (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic [2:0] ek [0:63];
    logic [7:0] eb [0:63];
    int en;
    logic [COL_W-1:0] m_col = '0;
    logic m_spare = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int b);
        ek[en] = 3'(k); eb[en] = 8'(b); en++;
    endtask

    task automatic push_addr(input bit sc, input int cv, input bit sp, input int pg, input bit lg, input int rb);
        int nr;
        nr = (rb == 0) ? 1 : (rb > ROW_MAX ? ROW_MAX : rb);
        if (sc) begin
            push(1, cv & 255);
            if (lg) push(1, (cv >> 8) & 255);
        end
        if (sp) for (int i = 0; i < nr; i++) push(1, (pg >> (8*i)) & 255);
    endtask

    task automatic push_read(input bit pv, input int pg, input bit lg, input int rb);
        push(0, 8'h00);
        push_addr(1, 0, pv, pg, lg, rb);
        if (lg) push(0, 8'h30);
        push(2, 0);
    endtask

    task automatic finish_up;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    task automatic run(input int op, input bit cv, input int col, input bit pv, input int pg,
                       input bit lg, input int rb, input bit b16);
        string tag;
        int got;
        bool_t_dummy: begin end
        en = 0;
        case (op)
            0: begin tag = "R4";  push_read(pv, pg, lg, rb); end
            1: begin tag = "R5";  push_read(pv, pg, lg, rb); end
            2: begin tag = "R6";  push_read(pv, pg, lg, rb); end
            3: begin tag = "R7";  push_read(pv, pg, lg, rb); push(0, 8'h80); push_addr(1, 0, pv, pg, lg, rb); end
            4: begin tag = "R8";  push(3, 0); push(0, 8'h10); end
            5: begin tag = "R9";  push(0, 8'h60); push_addr(cv, col, pv, pg, lg, rb); end
            6: begin tag = "R9";  push(0, 8'hD0); push_addr(cv, col, pv, pg, lg, rb); end
            7: begin tag = "R9";  push(0, 8'h90); push_addr(cv, col, pv, pg, lg, rb); push(4, 0); end
            8: begin tag = "R9";  push(0, 8'h70); push_addr(cv, col, pv, pg, lg, rb); push(5, 0); end
            default: tag = "R11";
        endcase
        if (op <= 8) begin
            m_spare = (op == 2);
            if (op == 1) m_col = (cv ? COL_W'(col) : '0) + COL_W'(256);
            else if (op == 8) m_col = COL_W'(b16);
            else m_col = cv ? COL_W'(col) : '0;
        end
        @(negedge clk);
        chk(req_ready, "R1 idle before request", req_ready, 1);
        cfg_large_page = lg; cfg_row_bytes = ROWC_W'(rb); cfg_bus16 = b16;
        req_op = 4'(op); req_col_vld = cv; req_col = COL_W'(col);
        req_page_vld = pv; req_page = PAGE_W'(pg); req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(col_out == m_col, (op == 8) ? "R10 column" : (op == 1) ? "R5 column" :
            (op > 8) ? "R11 column" : "R12 column", col_out, m_col);
        chk(spare_out == m_spare, (op > 8) ? "R11 spare" : "R6 spare", spare_out, m_spare);
        if (op <= 8) chk(!req_ready, "R1 busy after accept", req_ready, 0);
        got = 0;
        for (int t = 0; t < 100; t++) begin
            out_ready = ((cyc % 3) != 2);
            #1;
            if (req_ready && !out_valid) break;
            if (out_valid && out_ready) begin
                if (got < en)
                    chk(out_kind == ek[got] && out_byte == eb[got],
                        (ek[got] == 1) ? {tag, " R2 R3 addr"} : tag,
                        {out_kind, out_byte}, {ek[got], eb[got]});
                got++;
            end
            @(negedge clk);
        end
        out_ready = 1;
        chk(got == en, {tag, " item count"}, got, en);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !out_valid && col_out == 0 && !spare_out, "R1 reset state",
            {req_ready, out_valid, spare_out}, 3'b100);
        rst_n = 1;
        for (int op = 0; op < 16; op++)
            for (int lg = 0; lg < 2; lg++)
                for (int rb = 0; rb < 4; rb++)
                    for (int f = 0; f < 4; f++)
                        run(op, f[0], (op * 4111 + rb * 257 + f * 61 + 16'hFF35) & 16'hFFFF,
                            f[1], (op * 65537 + rb * 4099 + 24'h1A2B3C) & 24'hFFFFFF,
                            lg[0], rb, f[0] ^ lg[0]);
        // spare flag must survive an unsupported code (R11)
        run(2, 1, 16'h0040, 1, 24'h000123, 0, 1, 0);
        run(13, 1, 16'h7777, 1, 24'h000456, 1, 2, 1);
        // column wrap on upper half read (R5)
        run(1, 1, 16'hFF80, 0, 0, 1, 2, 0);
        finish_up();
    end
endmodule